// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Arbiter

This block picks which of seven interrupt requests the CPU should service next. Each request line has an enable bit, and a global enable bit gates all seven. Each source also has a priority bit that places it at the high or low level. Among the eligible requests, the highest-level one wins. Within a level, a fixed polling order breaks ties. The winner is reported as a vector address, together with a one-cycle taken strobe.

Two in-service bits, one per level, record which routines are running. While a low-level routine is in service, only a high-level request can interrupt it. While a high-level routine is in service, nothing can interrupt it. A return strobe from the CPU ends the most recently entered routine by clearing the highest in-service bit. The last source, the watchdog overflow, can be suppressed by an input that says the watchdog is in its reset mode.

Top module: `irq_arbiter7`

## Requirements
- R1: A source at index i (0..6) takes part in arbitration only when its request bit, enable bit i and the global enable bit 7 of the enable input are all 1. With bit 7 at 0, no interrupt is taken.
- R2: While the watchdog-reset-mode input is 1, the request on index 6 (watchdog overflow) is ignored. While that input is 0, index 6 behaves like any other source.
- R3: Priority bit i equal to 1 places source i at the high level. Any eligible high-level request wins over every eligible low-level request.
- R4: Within one level, the lowest index wins. The order, from first to last, is: index 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 A/D done, 6 watchdog.
- R5: The vector for index i is 0x0003 + 8*i. That gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B and 0x0033.
- R6: The taken strobe rises on the clock edge that samples a winning request and lasts one cycle. The vector output updates on that same edge and holds its value at all other times.
- R7: Taking an interrupt sets the in-service bit of its level. Bit 1 is the high level and bit 0 is the low level.
- R8: While only the low in-service bit is set, only high-level requests are taken. While the high in-service bit is set, no request is taken.
- R9: The return strobe clears the high in-service bit if it is set, and otherwise clears the low one. No interrupt is taken on the edge that samples the return strobe.
- R10: Synchronous reset clears the strobe, the vector and both in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Request lines, index 0 polled first |
| en_reg_i | input | 8 | Per-source enables in bits 6..0, global enable in bit 7 |
| pri_reg_i | input | 7 | Level select per source, 1 = high |
| wdt_rst_mode_i | input | 1 | Watchdog in reset mode; masks index 6 |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle interrupt-taken strobe |
| vec_o | output | 16 | Vector address of the last interrupt taken |
| insvc_o | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
The bench builds the arbiter with its default parameters: seven sources, a vector base of 0x0003, a stride of 8, a 16-bit vector and the watchdog at index 6. With these values, every vector in the list can be produced. The watchdog mask lands on the last polled source, so the table can show the mask removing a winner and the next row can show that same source winning alone. These defaults also let directed sequences reach nested service (low, then high), a blocked second high request, and the two-step unwinding by return strobes.

// File: rtl/irq7_pkg.sv
package irq7_pkg;

  typedef enum logic [0:0] {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;

  localparam int unsigned NUM_LVL = 2;

  // Address of the handler entry for a given polling index.
  function automatic logic [31:0] vec_addr(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned stride);
    return 32'(base + idx * stride);
  endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned WD_IDX  = NUM_SRC - 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC:0]   en_i,
  input  logic [NUM_SRC-1:0] pri_i,
  input  logic               wd_rst_mode_i,
  output logic [NUM_SRC-1:0] hi_cand_o,
  output logic [NUM_SRC-1:0] lo_cand_o
);

  logic [NUM_SRC-1:0] wd_keep;
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    wd_keep = '1;
    if (wd_rst_mode_i) wd_keep[WD_IDX] = 1'b0;
  end

  assign elig      = req_i & en_i[NUM_SRC-1:0] & wd_keep & {NUM_SRC{en_i[NUM_SRC]}};
  assign hi_cand_o = elig & pri_i;
  assign lo_cand_o = elig & ~pri_i;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  // Scan from the top so the lowest set index is the one kept.
  always_comb begin
    hit_o = |cand_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_hi_i,
  input  logic       set_lo_i,
  input  logic       ret_i,
  output logic [1:0] insvc_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc_o <= 2'b00;
    end else if (ret_i) begin
      if (insvc_o[1]) insvc_o[1] <= 1'b0;
      else            insvc_o[0] <= 1'b0;
    end else begin
      if (set_hi_i) insvc_o[1] <= 1'b1;
      if (set_lo_i) insvc_o[0] <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_arbiter7.sv
module irq_arbiter7 #(
  parameter int unsigned NUM_SRC    = 7,
  parameter int unsigned WD_IDX     = NUM_SRC - 1,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC:0]   en_reg_i,
  input  logic [NUM_SRC-1:0] pri_reg_i,
  input  logic               wdt_rst_mode_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [1:0]         insvc_o
);

  import irq7_pkg::*;

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] cand    [NUM_LVL];
  logic               hit     [NUM_LVL];
  logic [IDX_W-1:0]   pick_idx[NUM_LVL];
  logic               grant_hi;
  logic               grant_lo;
  logic [IDX_W-1:0]   win_idx;

  irq_src_gate #(
    .NUM_SRC(NUM_SRC),
    .WD_IDX (WD_IDX)
  ) u_gate (
    .req_i        (req_i),
    .en_i         (en_reg_i),
    .pri_i        (pri_reg_i),
    .wd_rst_mode_i(wdt_rst_mode_i),
    .hi_cand_o    (cand[LVL_HI]),
    .lo_cand_o    (cand[LVL_LO])
  );

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    irq_pick #(
      .N    (NUM_SRC),
      .IDX_W(IDX_W)
    ) u_pick (
      .cand_i(cand[lv]),
      .hit_o (hit[lv]),
      .idx_o (pick_idx[lv])
    );
  end

  // High level needs only the high routine idle; low level needs both idle
  // and no high contender. Nothing is granted while a return is sampled.
  always_comb begin
    grant_hi = hit[LVL_HI] && !insvc_o[1] && !reti_i;
    grant_lo = hit[LVL_LO] && !hit[LVL_HI] && (insvc_o == 2'b00) && !reti_i;
    win_idx  = grant_hi ? pick_idx[LVL_HI] : pick_idx[LVL_LO];
  end

  irq_svc_track u_svc (
    .clk     (clk),
    .rst     (rst),
    .set_hi_i(grant_hi),
    .set_lo_i(grant_lo),
    .ret_i   (reti_i),
    .insvc_o (insvc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= grant_hi | grant_lo;
      if (grant_hi | grant_lo) begin
        vec_o <= VEC_W'(vec_addr(32'(win_idx), VEC_BASE, VEC_STRIDE));
      end
    end
  end

endmodule

// File: rtl/irq_arbiter7_chk.sv
module irq_arbiter7_chk #(
  parameter int unsigned NUM_SRC    = 7,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             reti_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [1:0]       insvc_o
);

  logic        live;
  logic [31:0] vec32;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assign vec32 = 32'(vec_o);

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !take_o); // R1

  AST_VEC_IN_SET: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec32 >= VEC_BASE) && (vec32 < VEC_BASE + NUM_SRC * VEC_STRIDE)
               && (((vec32 - VEC_BASE) % VEC_STRIDE) == 0)); // R5

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (live && !take_o) |-> $stable(vec_o)); // R6

  AST_TAKE_MARKS: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (insvc_o != 2'b00)); // R7

  AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    insvc_o[1] |=> !take_o); // R8

  AST_LO_NEST_HI: assert property (@(posedge clk) disable iff (rst)
    (live && take_o && $past(insvc_o[0])) |-> insvc_o[1]); // R8

  AST_RET_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> !take_o); // R9

endmodule

bind irq_arbiter7 irq_arbiter7_chk #(
  .NUM_SRC   (NUM_SRC),
  .VEC_W     (VEC_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .glb_en (en_reg_i[NUM_SRC]),
  .reti_i (reti_i),
  .take_o (take_o),
  .vec_o  (vec_o),
  .insvc_o(insvc_o)
);

// File: tb/sim_irq_arbiter7.sv
`timescale 1ns/1ps
module sim_irq_arbiter7;

  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  req;
  logic [7:0]  en;
  logic [6:0]  pri;
  logic        wd;
  logic        ret;
  logic        take;
  logic [15:0] vec;
  logic [1:0]  insvc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter7 u0 (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req),
    .en_reg_i      (en),
    .pri_reg_i     (pri),
    .wdt_rst_mode_i(wd),
    .reti_i        (ret),
    .take_o        (take),
    .vec_o         (vec),
    .insvc_o       (insvc)
  );

  // Row fields: req[25:19] en[18:11] pri[10:4] wd[3] idx[2:0], idx 7 = no take.
  // Rows cover R1 (enables), R2 (watchdog mask), R3 (levels), R4 (order), R5 (vectors).
  localparam int NROW = 13;
  localparam logic [25:0] TBL [NROW] = '{
    {7'b0000001, 8'h81, 7'b0000000, 1'b0, 3'd0},
    {7'b1111111, 8'hFF, 7'b0000000, 1'b0, 3'd0},
    {7'b1111110, 8'hFF, 7'b0000000, 1'b0, 3'd1},
    {7'b1100000, 8'hFF, 7'b1000000, 1'b0, 3'd6},
    {7'b1100000, 8'hFF, 7'b1100000, 1'b0, 3'd5},
    {7'b1111111, 8'h7F, 7'b0000000, 1'b0, 3'd7},
    {7'b1000000, 8'hFF, 7'b0000000, 1'b1, 3'd7},
    {7'b1000000, 8'hFF, 7'b0000000, 1'b0, 3'd6},
    {7'b0010100, 8'h90, 7'b0000000, 1'b0, 3'd4},
    {7'b0001000, 8'h88, 7'b0001000, 1'b0, 3'd3},
    {7'b0000100, 8'hFF, 7'b0000000, 1'b0, 3'd2},
    {7'b0000011, 8'h82, 7'b0000000, 1'b0, 3'd1},
    {7'b0111111, 8'hFF, 7'b0100100, 1'b0, 3'd2}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic unwind();
    req = '0;
    ret = 1'b1;
    step();
    step();
    ret = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] last_vec;
    rst = 1'b1; req = '0; en = '0; pri = '0; wd = 1'b0; ret = 1'b0;
    @(negedge clk);
    step();
    // R10: reset state
    chk(take == 1'b0, "R10 take after reset", 32'(take), 0);
    chk(vec == 16'h0, "R10 vector after reset", 32'(vec), 0);
    chk(insvc == 2'b00, "R10 in-service after reset", 32'(insvc), 0);
    rst = 1'b0;
    step();
    last_vec = 16'h0;

    for (int r = 0; r < NROW; r++) begin
      logic [2:0]  idx;
      logic [15:0] exp_vec;
      {req, en, pri, wd, idx} = TBL[r];
      step();
      if (idx == 3'd7) begin
        chk(take == 1'b0, $sformatf("R1/R2 row %0d no take", r), 32'(take), 0);
        chk(vec == last_vec, $sformatf("R6 row %0d vector held", r), 32'(vec), 32'(last_vec));
      end else begin
        exp_vec = 16'(3 + 8 * int'(idx));
        chk(take == 1'b1, $sformatf("R1/R3/R4 row %0d taken", r), 32'(take), 1);
        chk(vec == exp_vec, $sformatf("R4/R5 row %0d vector", r), 32'(vec), 32'(exp_vec));
        chk(insvc == (pri[idx] ? 2'b10 : 2'b01), $sformatf("R7 row %0d level", r),
            32'(insvc), pri[idx] ? 32'd2 : 32'd1);
        last_vec = exp_vec;
      end
      unwind();
    end
    wd = 1'b0; en = 8'hFF;

    // R8: low routine preempted by high, high routine not preempted
    req = 7'b0000001; pri = 7'b0000000;
    step();
    chk(take && insvc == 2'b01, "R7 low entry", 32'(insvc), 1);
    req = 7'b1000001; pri = 7'b1000000;
    step();
    chk(take == 1'b1, "R8 high preempts low", 32'(take), 1);
    chk(vec == 16'h0033, "R8 preempt vector", 32'(vec), 32'h33);
    chk(insvc == 2'b11, "R8 both in service", 32'(insvc), 3);
    req = 7'b1100001; pri = 7'b1100000;
    step();
    chk(take == 1'b0, "R8 high cannot preempt high", 32'(take), 0);
    req = '0; ret = 1'b1;
    step();
    chk(insvc == 2'b01, "R9 return clears high first", 32'(insvc), 1);
    step();
    chk(insvc == 2'b00, "R9 second return clears low", 32'(insvc), 0);
    ret = 1'b0; pri = '0;

    // R8: low request while low in service
    req = 7'b0000001;
    step();
    req = 7'b0000011;
    step();
    chk(take == 1'b0, "R8 low cannot preempt low", 32'(take), 0);
    chk(vec == 16'h0003, "R8 vector unchanged", 32'(vec), 3);
    unwind();

    // R9/R6: return blocks a take, then one-cycle strobe
    req = 7'b0000010; ret = 1'b1;
    step();
    chk(take == 1'b0, "R9 no take with return", 32'(take), 0);
    ret = 1'b0;
    step();
    chk(take == 1'b1 && vec == 16'h000B, "R6 take after return", 32'(vec), 32'h0B);
    step();
    chk(take == 1'b0, "R6 strobe lasts one cycle", 32'(take), 0);

    // R10: reset while in service
    rst = 1'b1;
    step();
    chk(insvc == 2'b00 && take == 1'b0, "R10 reset clears service", 32'(insvc), 0);
    rst = 1'b0; req = '0;
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule